// File: doc/BRIEF.md
# Byte-wide host port slave with word RAM

This block lets an external host reach a 16-bit-word RAM held inside the block over an 8-bit parallel bus. The host picks one of three registers with a 2-bit select: a small control register, a word address pointer, or a data window onto the RAM. The data window comes in two flavours. One steps the pointer after each word and one leaves the pointer in place. Every word crosses the bus as two byte cycles. A byte-index input marks each byte as the first or the second one. A host-owned ordering bit decides whether the first byte is the high or the low half. The ordering applies to both data and pointer transfers.

The host strobe is brought into the block clock domain through a synchronizer. Select, byte index, direction and write data are taken when the strobe falls, and only if chip select is low at that moment. On the local side there is a plain RAM port and two pulse inputs. One raises the interrupt towards the host. The other clears the flag that the host sets to interrupt the local side. Setting that flag also fires a one-cycle local interrupt pulse.

Top module: `hpi_byte_slave`

## Requirements
- R1: After reset, host_int_n is 1, loc_int is 0, loc_flags is 0, and both the control register and the pointer read back as zero.
- R2: Select 2'b10 reaches the 16-bit pointer. Two written bytes load it after the second byte, and two read bytes return it.
- R3: The control register holds the ordering bit at bit 0, the local-interrupt flag at bit 1 and the host-interrupt bit at bit 2. With the ordering bit at 0 the first byte (byte index 0) is the high half of a word; with it at 1 the first byte is the low half.
- R4: Select 2'b01 writes the assembled word to RAM at the pointer, then adds one to the pointer.
- R5: Select 2'b11 moves words to or from RAM and leaves the pointer unchanged.
- R6: A data read fetches the whole word on the first byte. The second byte comes from that fetched copy, even if the RAM word changes between the two bytes.
- R7: After the second byte of a select 2'b01 read, the pointer has gone up by one.
- R8: The RAM is not written before the second byte of a data write arrives.
- R9: A host write to the control register with bit 1 set sets the local-interrupt flag and gives exactly one loc_int pulse of one cycle. loc_clr_dspint clears the flag.
- R10: loc_set_hint drives host_int_n low and sets bit 2. A host control write with bit 2 set returns host_int_n to 1.
- R11: A strobe falling while chip select is high changes no register and no RAM word.
- R12: The local port reads and writes RAM words directly. loc_flags shows {host-interrupt, local-interrupt} and never shows the ordering bit.
- R13: The control register acts only on the first of its two identical bytes, so a second byte with bit 1 set gives no extra loc_int pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_cs_n | input | 1 | Host chip select, active low |
| host_ds_n | input | 1 | Host data strobe, active low, falling edge samples |
| host_rw | input | 1 | 1 = host read, 0 = host write |
| host_cntl | input | 2 | Register select: 00 control, 01 data with step, 10 pointer, 11 data fixed |
| host_bil | input | 1 | Byte index: 0 first byte, 1 second byte |
| host_din | input | 8 | Write byte from host |
| host_dout | output | 8 | Read byte to host |
| host_doe | output | 1 | Host data drive enable during a read strobe |
| host_int_n | output | 1 | Interrupt to host, active low |
| loc_addr | input | AW | Local RAM word address |
| loc_we | input | 1 | Local RAM write enable |
| loc_wdata | input | 16 | Local RAM write word |
| loc_rdata | output | 16 | Local RAM read word |
| loc_set_hint | input | 1 | Pulse: raise the host interrupt |
| loc_clr_dspint | input | 1 | Pulse: clear the local-interrupt flag |
| loc_int | output | 1 | One-cycle local interrupt pulse |
| loc_flags | output | 2 | {host-interrupt bit, local-interrupt flag} |

## Verification
The bench goes after byte order in both ordering modes, for data and for the pointer. If the halves were swapped, words would come back byte-reversed, or a pointer would land on the wrong word. It changes a RAM word between the two bytes of a read. A design that fetched again on the second byte would return the new half. It also checks the RAM after only the first byte of a write, where an early write would leave a half-built word. It drives a doubled control write carrying the local-interrupt bit, where an extra pulse would show up, and a strobe with chip select high, where a pointer that moved would be caught on read-back. Pointer stepping is checked for both data selects after reads and after writes.

// File: rtl/hpi_pkg.sv
package hpi_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL     = 2'b00,
    SEL_DATA_INC = 2'b01,
    SEL_ADDR     = 2'b10,
    SEL_DATA_FIX = 2'b11
  } sel_e;

  localparam int WORD_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int BIT_BOB = 0;
  localparam int BIT_DSP = 1;
  localparam int BIT_HNT = 2;

  // assemble a word from first and second byte under the ordering bit
  function automatic logic [WORD_W-1:0] merge_word(input logic bob,
                                                   input logic [BYTE_W-1:0] first,
                                                   input logic [BYTE_W-1:0] second);
    return bob ? {second, first} : {first, second};
  endfunction

  // choose the byte of a word sent in the given slot
  function automatic logic [BYTE_W-1:0] pick_byte(input logic bob,
                                                  input logic [WORD_W-1:0] w,
                                                  input logic second);
    logic take_low;
    take_low = bob ^ second;
    return take_low ? w[BYTE_W-1:0] : w[WORD_W-1:BYTE_W];
  endfunction

  function automatic logic sel_is_data(input sel_e s);
    return (s == SEL_DATA_INC) || (s == SEL_DATA_FIX);
  endfunction
endpackage

// File: rtl/hpi_strobe_sync.sv
module hpi_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ds_n,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= ds_n;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= chain[STAGES-1];
  end

  assign fall = last_q & ~chain[STAGES-1];
endmodule

// File: rtl/hpi_word_ram.sv
module hpi_word_ram #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic [AW-1:0] h_addr,
  input  logic          h_we,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  input  logic [AW-1:0] l_addr,
  input  logic          l_we,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];
  logic          l_blocked;

  // host side wins a same-word collision
  assign l_blocked = h_we && (h_addr == l_addr);

  always_ff @(posedge clk) begin
    if (h_we) mem[h_addr] <= h_wdata;
    if (l_we && !l_blocked) mem[l_addr] <= l_wdata;
  end

  assign h_rdata = mem[h_addr];
  assign l_rdata = mem[l_addr];
endmodule

// File: rtl/hpi_regs.sv
module hpi_regs
  import hpi_pkg::*;
#(
  parameter int AW     = 8,
  parameter int PTR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  sel_e              sel,
  input  logic              rd,
  input  logic              second,
  input  logic [BYTE_W-1:0] din,
  input  logic [WORD_W-1:0] ram_rdata,
  input  logic              set_hint,
  input  logic              clr_dsp,
  output logic [BYTE_W-1:0] dout,
  output logic [PTR_W-1:0]  ptr,
  output logic              bob,
  output logic              dsp_flag,
  output logic              hint,
  output logic              lint,
  output logic              ram_we,
  output logic [AW-1:0]     ram_addr,
  output logic [WORD_W-1:0] ram_wdata
);
  logic [BYTE_W-1:0] hold_q;
  logic [WORD_W-1:0] snap_q;
  logic [BYTE_W-1:0] ctrl_byte;
  logic              wr_evt;
  logic              rd_evt;
  logic              step;

  assign wr_evt    = evt && !rd;
  assign rd_evt    = evt && rd;
  assign ctrl_byte = {{(BYTE_W-3){1'b0}}, hint, dsp_flag, bob};
  assign ram_addr  = ptr[AW-1:0];
  assign ram_wdata = merge_word(bob, hold_q, din);
  assign ram_we    = wr_evt && second && sel_is_data(sel);
  assign step      = evt && second && (sel == SEL_DATA_INC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      snap_q   <= '0;
      dout     <= '0;
      ptr      <= '0;
      bob      <= 1'b0;
      dsp_flag <= 1'b0;
      hint     <= 1'b0;
      lint     <= 1'b0;
    end else begin
      lint <= 1'b0;
      if (set_hint) hint     <= 1'b1;
      if (clr_dsp)  dsp_flag <= 1'b0;
      if (wr_evt) begin
        unique case (sel)
          SEL_CTRL: begin
            if (!second) begin
              bob <= din[BIT_BOB];
              if (din[BIT_DSP]) begin
                dsp_flag <= 1'b1;
                lint     <= 1'b1;
              end
              if (din[BIT_HNT]) hint <= 1'b0;
            end
          end
          SEL_ADDR: begin
            if (!second) hold_q <= din;
            else         ptr    <= merge_word(bob, hold_q, din);
          end
          default: begin
            if (!second) hold_q <= din;
          end
        endcase
      end
      if (rd_evt) begin
        unique case (sel)
          SEL_CTRL: dout <= ctrl_byte;
          SEL_ADDR: begin
            if (!second) begin
              snap_q <= ptr;
              dout   <= pick_byte(bob, ptr, 1'b0);
            end else begin
              dout   <= pick_byte(bob, snap_q, 1'b1);
            end
          end
          default: begin
            if (!second) begin
              snap_q <= ram_rdata;
              dout   <= pick_byte(bob, ram_rdata, 1'b0);
            end else begin
              dout   <= pick_byte(bob, snap_q, 1'b1);
            end
          end
        endcase
      end
      if (step) ptr <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/hpi_byte_slave.sv
module hpi_byte_slave
  import hpi_pkg::*;
#(
  parameter int AW          = 8,
  parameter int PTR_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cs_n,
  input  logic              host_ds_n,
  input  logic              host_rw,
  input  logic [1:0]        host_cntl,
  input  logic              host_bil,
  input  logic [7:0]        host_din,
  output logic [7:0]        host_dout,
  output logic              host_doe,
  output logic              host_int_n,
  input  logic [AW-1:0]     loc_addr,
  input  logic              loc_we,
  input  logic [15:0]       loc_wdata,
  output logic [15:0]       loc_rdata,
  input  logic              loc_set_hint,
  input  logic              loc_clr_dspint,
  output logic              loc_int,
  output logic [1:0]        loc_flags
);
  logic              ds_fall;
  logic              host_evt;
  sel_e              evt_sel;
  logic [PTR_W-1:0]  hpia;
  logic              bob;
  logic              dsp_flag;
  logic              hint;
  logic              ram_we;
  logic [AW-1:0]     ram_addr;
  logic [WORD_W-1:0] ram_wdata;
  logic [WORD_W-1:0] ram_rdata;

  hpi_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .ds_n (host_ds_n),
    .fall (ds_fall)
  );

  assign host_evt = ds_fall && !host_cs_n;
  assign evt_sel  = sel_e'(host_cntl);

  hpi_regs #(.AW(AW), .PTR_W(PTR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (host_evt),
    .sel      (evt_sel),
    .rd       (host_rw),
    .second   (host_bil),
    .din      (host_din),
    .ram_rdata(ram_rdata),
    .set_hint (loc_set_hint),
    .clr_dsp  (loc_clr_dspint),
    .dout     (host_dout),
    .ptr      (hpia),
    .bob      (bob),
    .dsp_flag (dsp_flag),
    .hint     (hint),
    .lint     (loc_int),
    .ram_we   (ram_we),
    .ram_addr (ram_addr),
    .ram_wdata(ram_wdata)
  );

  hpi_word_ram #(.AW(AW), .DW(WORD_W)) u_ram (
    .clk    (clk),
    .h_addr (ram_addr),
    .h_we   (ram_we),
    .h_wdata(ram_wdata),
    .h_rdata(ram_rdata),
    .l_addr (loc_addr),
    .l_we   (loc_we),
    .l_wdata(loc_wdata),
    .l_rdata(loc_rdata)
  );

  assign host_doe   = !host_cs_n && !host_ds_n && host_rw;
  assign host_int_n = !hint;
  assign loc_flags  = {hint, dsp_flag};
endmodule

// File: rtl/hpi_byte_slave_chk.sv
module hpi_byte_slave_chk #(
  parameter int PTR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_evt,
  input logic [1:0]       host_cntl,
  input logic             host_rw,
  input logic             host_bil,
  input logic [7:0]       host_din,
  input logic [PTR_W-1:0] hpia,
  input logic             loc_int,
  input logic             loc_set_hint,
  input logic             host_int_n,
  input logic [1:0]       loc_flags
);
  // pointer steps by one after the second byte of a stepping data write
  assert_step_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_evt && !host_rw && host_bil && host_cntl == 2'b01)
      |=> (hpia == $past(hpia) + 1'b1));

  // fixed data select never moves the pointer
  assert_fixed_keeps_ptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_evt && host_cntl == 2'b11) |=> $stable(hpia));

  // pointer steps by one after the second byte of a stepping data read
  assert_step_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_evt && host_rw && host_bil && host_cntl == 2'b01)
      |=> (hpia == $past(hpia) + 1'b1));

  // local interrupt pulse lasts one cycle
  assert_lint_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    loc_int |=> !loc_int);

  // control write with the flag bit raises the pulse and the flag
  assert_lint_on_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_evt && !host_rw && !host_bil && host_cntl == 2'b00 && host_din[1])
      |=> (loc_int && loc_flags[0]));

  // local request pulls the host line low unless the host clears it at once
  assert_hint_raise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_set_hint && !host_evt) |=> !host_int_n);

  // second control byte never fires a pulse
  assert_second_ctrl_silent_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (host_evt && !host_rw && host_bil && host_cntl == 2'b00) |=> !loc_int);
endmodule

bind hpi_byte_slave hpi_byte_slave_chk #(.PTR_W(PTR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_evt    (host_evt),
  .host_cntl   (host_cntl),
  .host_rw     (host_rw),
  .host_bil    (host_bil),
  .host_din    (host_din),
  .hpia        (hpia),
  .loc_int     (loc_int),
  .loc_set_hint(loc_set_hint),
  .host_int_n  (host_int_n),
  .loc_flags   (loc_flags)
);

// File: tb/tb_hpi_byte_slave.sv
`timescale 1ns/1ps
module tb_hpi_byte_slave;
  localparam int AW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_cs_n = 1'b1, host_ds_n = 1'b1, host_rw = 1'b0, host_bil = 1'b0;
  logic [1:0]  host_cntl = 2'b00;
  logic [7:0]  host_din = 8'h00;
  logic [7:0]  host_dout;
  logic        host_doe, host_int_n;
  logic [AW-1:0] loc_addr = '0;
  logic        loc_we = 1'b0, loc_set_hint = 1'b0, loc_clr_dspint = 1'b0;
  logic [15:0] loc_wdata = '0;
  logic [15:0] loc_rdata;
  logic        loc_int;
  logic [1:0]  loc_flags;

  int checks = 0, errors = 0, pulses = 0;
  bit done = 0;

  // reference state
  int m_ptr = 0;
  bit m_bob = 0;
  int m_mem [int];

  always #2 clk = ~clk;

  hpi_byte_slave dut (.*);

  always @(posedge clk) if (loc_int === 1'b1) pulses++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus(input bit cs, input bit rd, input int sel, input bit second,
                     input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    host_cs_n = !cs; host_rw = rd; host_cntl = sel[1:0]; host_bil = second; host_din = d;
    host_ds_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    q = host_dout;
    host_ds_n = 1'b1; host_cs_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  function automatic logic [7:0] slot(input logic [15:0] w, input bit second);
    bit lo = (m_bob && !second) || (!m_bob && second);
    return lo ? w[7:0] : w[15:8];
  endfunction

  task automatic wr16(input int sel, input logic [15:0] w);
    logic [7:0] q;
    bus(1, 0, sel, 0, slot(w, 0), q);
    bus(1, 0, sel, 1, slot(w, 1), q);
    if (sel == 2) m_ptr = w;
    if (sel == 1 || sel == 3) m_mem[m_ptr & 255] = w;
    if (sel == 1) m_ptr = (m_ptr + 1) & 16'hFFFF;
  endtask

  task automatic rd16(input int sel, output logic [15:0] w);
    logic [7:0] a, b;
    bus(1, 1, sel, 0, 8'h00, a);
    bus(1, 1, sel, 1, 8'h00, b);
    w = m_bob ? {b, a} : {a, b};
    if (sel == 1) m_ptr = (m_ptr + 1) & 16'hFFFF;
  endtask

  task automatic ctrl_wr(input logic [7:0] v);
    logic [7:0] q;
    bus(1, 0, 0, 0, v, q);
    bus(1, 0, 0, 1, v, q);
    m_bob = v[0];
  endtask

  task automatic lwr(input int a, input logic [15:0] w);
    @(negedge clk);
    loc_addr = a[AW-1:0]; loc_wdata = w; loc_we = 1'b1;
    @(negedge clk);
    loc_we = 1'b0;
    m_mem[a] = w;
  endtask

  task automatic lrd(input int a, output logic [15:0] w);
    @(negedge clk);
    loc_addr = a[AW-1:0];
    #1 w = loc_rdata;
  endtask

  initial begin
    logic [15:0] w;
    logic [7:0] q;
    int p0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 host_int_n", host_int_n, 1);
    chk("R1 loc_int", loc_int, 0);
    chk("R1 loc_flags", loc_flags, 0);
    bus(1, 1, 0, 0, 8'h00, q); chk("R1 ctrl", q, 0);
    rd16(2, w); chk("R1 pointer", w, 0);

    // R2/R3 pointer with high byte first
    ctrl_wr(8'h00);
    wr16(2, 16'h0010);
    rd16(2, w); chk("R2 pointer", w, 16'h0010);
    bus(1, 1, 2, 0, 8'h00, q); chk("R3 first byte high", q, 8'h00);

    // R4 stepping write
    wr16(1, 16'h1234);
    rd16(2, w); chk("R4 pointer step", w, 16'h0011);
    lrd(16'h10, w); chk("R12 local read", w, 16'h1234);

    // R8 no write before second byte; R5 fixed write
    lwr(16'h11, 16'hAAAA);
    bus(1, 0, 3, 0, 8'h77, q);
    lrd(16'h11, w); chk("R8 no early write", w, 16'hAAAA);
    bus(1, 0, 3, 1, 8'h66, q);
    m_mem[16'h11] = 16'h7766;
    lrd(16'h11, w); chk("R8 word after second", w, 16'h7766);
    rd16(2, w); chk("R5 pointer fixed", w, 16'h0011);
    rd16(3, w); chk("R5 fixed read", w, 16'h7766);
    rd16(2, w); chk("R5 pointer after read", w, 16'h0011);

    // R3 low byte first
    ctrl_wr(8'h01);
    bus(1, 1, 0, 0, 8'h00, q); chk("R3 ctrl bob", q, 8'h01);
    chk("R12 flags hide bob", loc_flags, 0);
    wr16(2, 16'h0020);
    rd16(2, w); chk("R3 pointer low first", w, 16'h0020);
    wr16(1, 16'hBEEF);
    lrd(16'h20, w); chk("R3 data low first", w, 16'hBEEF);
    wr16(2, 16'h0020);
    bus(1, 1, 3, 0, 8'h00, q); chk("R3 first byte low", q, 8'hEF);
    bus(1, 1, 3, 1, 8'h00, q); chk("R3 second byte high", q, 8'hBE);

    // R6/R7 read snapshot and step
    lwr(16'h30, 16'h5A3C);
    wr16(2, 16'h0030);
    bus(1, 1, 1, 0, 8'h00, q); chk("R6 first byte", q, 8'h3C);
    lwr(16'h30, 16'h0000);
    bus(1, 1, 1, 1, 8'h00, q); chk("R6 second from copy", q, 8'h5A);
    m_ptr = 16'h31;
    rd16(2, w); chk("R7 pointer after read", w, 16'h0031);

    // R9/R13 local interrupt
    p0 = pulses;
    ctrl_wr(8'h03);
    chk("R13 one pulse", pulses - p0, 1);
    chk("R9 flag set", loc_flags[0], 1);
    @(negedge clk) loc_clr_dspint = 1'b1;
    @(negedge clk) loc_clr_dspint = 1'b0;
    chk("R9 flag cleared", loc_flags[0], 0);

    // R10 host interrupt
    @(negedge clk) loc_set_hint = 1'b1;
    @(negedge clk) loc_set_hint = 1'b0;
    chk("R10 host_int_n low", host_int_n, 0);
    chk("R10 flag bit", loc_flags[1], 1);
    bus(1, 1, 0, 0, 8'h00, q); chk("R10 ctrl bit2", q, 8'h05);
    p0 = pulses;
    ctrl_wr(8'h05);
    chk("R10 host clear", host_int_n, 1);
    chk("R10 no pulse", pulses - p0, 0);

    // R11 deselected strobe
    wr16(2, 16'h0040);
    bus(0, 0, 2, 0, 8'h99, q);
    bus(0, 0, 2, 1, 8'h99, q);
    bus(0, 0, 1, 1, 8'h99, q);
    rd16(2, w); chk("R11 pointer kept", w, 16'h0040);

    // burst with stepping, checked against reference memory
    for (int i = 0; i < 4; i++) wr16(1, 16'h1000 + 16'(i * 16'h0111));
    for (int i = 0; i < 4; i++) begin
      lrd(16'h40 + i, w); chk("R4 burst", w, m_mem[16'h40 + i]);
    end
    wr16(2, 16'h0040);
    for (int i = 0; i < 4; i++) begin
      rd16(1, w); chk("R7 burst read", w, m_mem[16'h40 + i]);
    end
    rd16(2, w); chk("R7 pointer end", w, m_ptr);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule